// File: doc/BRIEF.md
# Speculative Path History Buffer

This block keeps the recent indirect branches of one hardware thread in program order, oldest to youngest. Each entry records the branch address, its predicted target and the sequence number the pipeline gave the branch. The front end appends an entry for every indirect branch it predicts. The back end retires entries by sequence number as they commit. On a flush it discards every entry younger than a given sequence number. After a misprediction it writes the resolved target into the youngest entry.

The newest targets, up to a path length, go straight out to the index hash of an indirect target predictor. Committed entries stay in the buffer as hashing context, so that the history the hash sees does not shrink at retirement. An entry is removed at commit only once the committed-head position has reached the path length.

The storage is a circular array with a base pointer, an occupancy count and a committed-head position. Depth, address width, sequence-number width and path length are parameters.

Top module: `path_hist_buffer`

## Requirements
- R1: After reset the buffer is empty: occupancy 0, committed-head position 0 and every tap marked invalid.
- R2: A push with no squash in the same cycle appends an entry holding the pushed address, target and sequence number at the young end. From the next cycle the youngest-entry outputs show that entry, and a buffer that was not full grows by one.
- R3: A push into a full buffer (occupancy equal to DEPTH) drops the oldest entry, so occupancy stays DEPTH. The committed-head position decreases by one unless it is already 0.
- R4: A commit acts only when all three of these hold: the buffer is non-empty, the committed-head position is less than the occupancy, and the entry at that position (counted from the oldest, starting at 0) has a sequence number that is unsigned less than or equal to the commit sequence number. While the head position is below PATH_LEN, such a commit advances it by one and removes nothing.
- R5: An acting commit while the head position has already reached PATH_LEN removes the oldest entry. Occupancy falls by one and the head position stays unchanged.
- R6: A commit that fails any of the R4 conditions changes neither occupancy, head position nor any entry.
- R7: A squash finds the first entry, scanning from the oldest, whose sequence number is unsigned greater than the squash sequence number. It removes that entry and every younger one. The head position is clamped to the new occupancy.
- R8: A squash that finds no entry greater than its sequence number leaves the buffer unchanged.
- R9: A target correction replaces the target of the youngest entry and keeps that entry's address and sequence number. On an empty buffer it has no effect.
- R10: Tap g (0 to PATH_LEN-1) carries the target of the g-th youngest entry, with g = 0 as the youngest. Tap g is valid exactly when occupancy exceeds g. Tap g sits in bits [g*ADDR_W +: ADDR_W] of the tap bus and bit g of the tap-valid vector.
- R11: Only one operation takes effect per cycle. The priority order is squash, then push, then target correction, then commit, and any lower-priority request in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid_i | input | 1 | Append a predicted branch |
| push_addr_i | input | ADDR_W | Branch address to append |
| push_tgt_i | input | ADDR_W | Predicted target to append |
| push_seq_i | input | SEQ_W | Sequence number to append |
| commit_valid_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Entries above this sequence number are removed |
| fix_valid_i | input | 1 | Target correction request |
| fix_tgt_i | input | ADDR_W | Resolved target for the youngest entry |
| count_o | output | $clog2(DEPTH+1) | Occupancy |
| head_o | output | $clog2(DEPTH+1) | Committed-head position |
| oldest_seq_o | output | SEQ_W | Sequence number of the oldest entry |
| young_addr_o | output | ADDR_W | Address of the youngest entry |
| young_tgt_o | output | ADDR_W | Target of the youngest entry |
| young_seq_o | output | SEQ_W | Sequence number of the youngest entry |
| tap_tgt_o | output | PATH_LEN*ADDR_W | Youngest-first targets for the index hash |
| tap_valid_o | output | PATH_LEN | Per-tap valid |

## Verification
The bench builds the block with DEPTH 8, ADDR_W 16, SEQ_W 8 and PATH_LEN 3. With a depth of 8, a handful of pushes fill the buffer and wrap the base pointer, so overflow with a non-zero head position is reachable. With a path length of 3, the switch between a commit that advances the head and a commit that retires an entry comes after three commits. Squashes are aimed at a mid-buffer entry, at no entry and at every entry, across a wrapped array. Collisions between requests check the priority order.

// File: rtl/phb_pkg.sv
package phb_pkg;

   typedef enum logic [2:0] {
      PHB_IDLE,
      PHB_SQUASH,
      PHB_PUSH,
      PHB_FIX,
      PHB_COMMIT
   } phb_op_e;

   // R11: one operation per cycle, squash > push > fix > commit
   function automatic phb_op_e phb_pick(input logic sq, input logic pu,
                                        input logic fx, input logic cm);
      phb_op_e op;
      if (sq)      op = PHB_SQUASH;
      else if (pu) op = PHB_PUSH;
      else if (fx) op = PHB_FIX;
      else if (cm) op = PHB_COMMIT;
      else         op = PHB_IDLE;
      return op;
   endfunction

endpackage

// File: rtl/phb_store.sv
module phb_store #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 32,
   parameter int SEQ_W  = 16,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ent_we,
   input  logic [IDX_W-1:0]  ent_idx,
   input  logic [ADDR_W-1:0] ent_addr,
   input  logic [ADDR_W-1:0] ent_tgt,
   input  logic [SEQ_W-1:0]  ent_seq,
   input  logic              tgt_we,
   input  logic [IDX_W-1:0]  tgt_idx,
   input  logic [ADDR_W-1:0] tgt_val,
   output logic [ADDR_W-1:0] addr_q [DEPTH],
   output logic [ADDR_W-1:0] tgt_q  [DEPTH],
   output logic [SEQ_W-1:0]  seq_q  [DEPTH]
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            addr_q[i] <= '0;
            tgt_q[i]  <= '0;
            seq_q[i]  <= '0;
         end
      end else begin
         if (ent_we) begin
            addr_q[ent_idx] <= ent_addr;
            tgt_q[ent_idx]  <= ent_tgt;
            seq_q[ent_idx]  <= ent_seq;
         end
         if (tgt_we) tgt_q[tgt_idx] <= tgt_val;
      end
   end

   // R11: the control never writes a whole entry and a target together
   a_r11_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(ent_we && tgt_we));

endmodule

// File: rtl/phb_squash_scan.sv
module phb_squash_scan #(
   parameter int DEPTH = 16,
   parameter int SEQ_W = 16,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [SEQ_W-1:0] seq_q [DEPTH],
   input  logic [IDX_W-1:0] base_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [SEQ_W-1:0] key_i,
   output logic             hit_o,
   output logic [CNT_W-1:0] pos_o
);

   logic [DEPTH-1:0] younger;

   // logical position p maps to physical slot base + p
   for (genvar p = 0; p < DEPTH; p++) begin : g_cmp
      logic [IDX_W-1:0] slot;
      assign slot       = base_i + IDX_W'(p);
      assign younger[p] = (CNT_W'(p) < cnt_i) && (seq_q[slot] > key_i);
   end

   // R7: first hit counted from the oldest end
   always_comb begin
      pos_o = cnt_i;
      for (int p = DEPTH - 1; p >= 0; p--) begin
         if (younger[p]) pos_o = CNT_W'(p);
      end
   end

   assign hit_o = |younger;

endmodule

// File: rtl/phb_tap_select.sv
module phb_tap_select #(
   parameter int DEPTH     = 16,
   parameter int ADDR_W    = 32,
   parameter int PATH_LEN  = 3,
   parameter bit ZERO_IDLE = 1'b1,
   parameter int IDX_W     = $clog2(DEPTH),
   parameter int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic [ADDR_W-1:0]          tgt_q [DEPTH],
   input  logic [IDX_W-1:0]           base_i,
   input  logic [CNT_W-1:0]           cnt_i,
   output logic [PATH_LEN*ADDR_W-1:0] tap_tgt_o,
   output logic [PATH_LEN-1:0]        tap_valid_o
);

   logic [IDX_W-1:0] cnt_lo;
   assign cnt_lo = cnt_i[IDX_W-1:0];

   // R10: tap g is the g-th youngest entry
   for (genvar g = 0; g < PATH_LEN; g++) begin : g_tap
      logic [IDX_W-1:0] slot;
      assign slot           = base_i + cnt_lo - IDX_W'(1) - IDX_W'(g);
      assign tap_valid_o[g] = cnt_i > CNT_W'(g);
      if (ZERO_IDLE) begin : g_zero
         assign tap_tgt_o[g*ADDR_W +: ADDR_W] = tap_valid_o[g] ? tgt_q[slot] : '0;
      end else begin : g_raw
         assign tap_tgt_o[g*ADDR_W +: ADDR_W] = tgt_q[slot];
      end
   end

endmodule

// File: rtl/path_hist_buffer.sv
module path_hist_buffer
   import phb_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int ADDR_W    = 32,
   parameter int SEQ_W     = 16,
   parameter int PATH_LEN  = 3,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push_valid_i,
   input  logic [ADDR_W-1:0]              push_addr_i,
   input  logic [ADDR_W-1:0]              push_tgt_i,
   input  logic [SEQ_W-1:0]               push_seq_i,
   input  logic                           commit_valid_i,
   input  logic [SEQ_W-1:0]               commit_seq_i,
   input  logic                           squash_valid_i,
   input  logic [SEQ_W-1:0]               squash_seq_i,
   input  logic                           fix_valid_i,
   input  logic [ADDR_W-1:0]              fix_tgt_i,
   output logic [$clog2(DEPTH+1)-1:0]     count_o,
   output logic [$clog2(DEPTH+1)-1:0]     head_o,
   output logic [SEQ_W-1:0]               oldest_seq_o,
   output logic [ADDR_W-1:0]              young_addr_o,
   output logic [ADDR_W-1:0]              young_tgt_o,
   output logic [SEQ_W-1:0]               young_seq_o,
   output logic [PATH_LEN*ADDR_W-1:0]     tap_tgt_o,
   output logic [PATH_LEN-1:0]            tap_valid_o
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("path_hist_buffer: DEPTH must be a power of two, at least 2");
   end
   if (PATH_LEN < 1 || PATH_LEN > DEPTH) begin : g_bad_path
      $error("path_hist_buffer: PATH_LEN must lie in 1..DEPTH");
   end
   if (ADDR_W < 1 || SEQ_W < 1) begin : g_bad_width
      $error("path_hist_buffer: widths must be positive");
   end

   logic [IDX_W-1:0]  base_q, base_n;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [CNT_W-1:0]  head_q, head_n;

   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [ADDR_W-1:0] tgt_q  [DEPTH];
   logic [SEQ_W-1:0]  seq_q  [DEPTH];

   logic              ent_we, tgt_we;
   logic [IDX_W-1:0]  ent_idx;
   logic [IDX_W-1:0]  cnt_lo, young_idx, head_idx;
   logic              full, cm_ok, cm_drop;
   logic              scan_hit;
   logic [CNT_W-1:0]  scan_pos;
   phb_op_e           op;

   assign cnt_lo    = cnt_q[IDX_W-1:0];
   assign young_idx = base_q + cnt_lo - IDX_W'(1);
   assign head_idx  = base_q + head_q[IDX_W-1:0];
   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign op        = phb_pick(squash_valid_i, push_valid_i, fix_valid_i, commit_valid_i);

   // R4, R6: commit gate; R5: retire once the head reached the path length
   assign cm_ok   = (cnt_q != '0) && (head_q < cnt_q) && (seq_q[head_idx] <= commit_seq_i);
   assign cm_drop = (head_q >= CNT_W'(PATH_LEN));

   phb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .ent_we   (ent_we),
      .ent_idx  (ent_idx),
      .ent_addr (push_addr_i),
      .ent_tgt  (push_tgt_i),
      .ent_seq  (push_seq_i),
      .tgt_we   (tgt_we),
      .tgt_idx  (young_idx),
      .tgt_val  (fix_tgt_i),
      .addr_q   (addr_q),
      .tgt_q    (tgt_q),
      .seq_q    (seq_q)
   );

   phb_squash_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan (
      .seq_q  (seq_q),
      .base_i (base_q),
      .cnt_i  (cnt_q),
      .key_i  (squash_seq_i),
      .hit_o  (scan_hit),
      .pos_o  (scan_pos)
   );

   phb_tap_select #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PATH_LEN(PATH_LEN),
                    .ZERO_IDLE(ZERO_IDLE), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_taps (
      .tgt_q       (tgt_q),
      .base_i      (base_q),
      .cnt_i       (cnt_q),
      .tap_tgt_o   (tap_tgt_o),
      .tap_valid_o (tap_valid_o)
   );

   always_comb begin
      base_n  = base_q;
      cnt_n   = cnt_q;
      head_n  = head_q;
      ent_we  = 1'b0;
      ent_idx = base_q + cnt_lo;
      tgt_we  = 1'b0;
      unique case (op)
         PHB_SQUASH: begin                       // R7, R8
            cnt_n  = scan_pos;
            head_n = (head_q > scan_pos) ? scan_pos : head_q;
         end
         PHB_PUSH: begin                         // R2, R3
            ent_we = 1'b1;
            if (full) begin
               ent_idx = base_q;
               base_n  = base_q + IDX_W'(1);
               if (head_q != '0) head_n = head_q - CNT_W'(1);
            end else begin
               cnt_n = cnt_q + CNT_W'(1);
            end
         end
         PHB_FIX: begin                          // R9
            tgt_we = (cnt_q != '0);
         end
         PHB_COMMIT: begin                       // R4, R5, R6
            if (cm_ok) begin
               if (cm_drop) begin
                  base_n = base_q + IDX_W'(1);
                  cnt_n  = cnt_q - CNT_W'(1);
               end else begin
                  head_n = head_q + CNT_W'(1);
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin                          // R1
         base_q <= '0;
         cnt_q  <= '0;
         head_q <= '0;
      end else begin
         base_q <= base_n;
         cnt_q  <= cnt_n;
         head_q <= head_n;
      end
   end

   assign count_o      = cnt_q;
   assign head_o       = head_q;
   assign oldest_seq_o = seq_q[base_q];
   assign young_addr_o = addr_q[young_idx];
   assign young_tgt_o  = tgt_q[young_idx];
   assign young_seq_o  = seq_q[young_idx];

   a_r2_push_appends: assert property (@(posedge clk) disable iff (!rst_n)
      (op == PHB_PUSH && !full) |=>
         (cnt_q == $past(cnt_q) + CNT_W'(1)) && (young_seq_o == $past(push_seq_i)));

   a_r3_full_push_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (op == PHB_PUSH && full) |=> (cnt_q == CNT_W'(DEPTH)) && (young_addr_o == $past(push_addr_i)));

   a_r5_commit_retires: assert property (@(posedge clk) disable iff (!rst_n)
      (op == PHB_COMMIT && cm_ok && cm_drop) |=>
         (cnt_q == $past(cnt_q) - CNT_W'(1)) && (head_q == $past(head_q)));

   a_r6_head_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (head_q <= cnt_q) && (head_q <= CNT_W'(PATH_LEN)));

   a_r8_squash_miss_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (op == PHB_SQUASH && !scan_hit) |=> $stable(cnt_q) && $stable(base_q));

   a_r9_fix_keeps_key: assert property (@(posedge clk) disable iff (!rst_n)
      (op == PHB_FIX && cnt_q != '0) |=>
         (young_seq_o == $past(young_seq_o)) && (young_tgt_o == $past(fix_tgt_i)));

endmodule

// File: tb/path_hist_buffer_test.sv
module path_hist_buffer_test;

   localparam int DEPTH = 8;
   localparam int AW    = 16;
   localparam int SW    = 8;
   localparam int PL    = 3;
   localparam int CW    = $clog2(DEPTH + 1);

   typedef struct {
      logic [AW-1:0] addr;
      logic [AW-1:0] tgt;
      logic [SW-1:0] seq;
   } ent_t;

   typedef struct {
      string         tag;
      int            cnt;
      int            head;
      logic [SW-1:0] oseq;
      logic [AW-1:0] yaddr;
      logic [AW-1:0] ytgt;
      logic [SW-1:0] yseq;
      logic [AW-1:0] taps [PL];
   } snap_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          push_v = 0, cm_v = 0, sq_v = 0, fx_v = 0;
   logic [AW-1:0] push_a = '0, push_t = '0, fx_t = '0;
   logic [SW-1:0] push_s = '0, cm_s = '0, sq_s = '0;
   logic [CW-1:0] count_o, head_o;
   logic [SW-1:0] oldest_seq_o, young_seq_o;
   logic [AW-1:0] young_addr_o, young_tgt_o;
   logic [PL*AW-1:0] tap_tgt_o;
   logic [PL-1:0] tap_valid_o;

   path_hist_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .SEQ_W(SW), .PATH_LEN(PL)) uut (
      .clk(clk), .rst_n(rst_n),
      .push_valid_i(push_v), .push_addr_i(push_a), .push_tgt_i(push_t), .push_seq_i(push_s),
      .commit_valid_i(cm_v), .commit_seq_i(cm_s),
      .squash_valid_i(sq_v), .squash_seq_i(sq_s),
      .fix_valid_i(fx_v), .fix_tgt_i(fx_t),
      .count_o(count_o), .head_o(head_o), .oldest_seq_o(oldest_seq_o),
      .young_addr_o(young_addr_o), .young_tgt_o(young_tgt_o), .young_seq_o(young_seq_o),
      .tap_tgt_o(tap_tgt_o), .tap_valid_o(tap_valid_o)
   );

   int checks = 0, fails = 0;
   bit done = 0;
   ent_t  mq[$];
   int    mh = 0;
   snap_t exp_q[$];

   task automatic chk(input string tag, input string what, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // model of the requirements, one operation per call
   task automatic model(input bit sq, input logic [SW-1:0] sk, input bit pu, input ent_t pe,
                        input bit fx, input logic [AW-1:0] ft, input bit cm, input logic [SW-1:0] ck);
      if (sq) begin
         int cut = mq.size();
         for (int i = mq.size() - 1; i >= 0; i--) if (mq[i].seq > sk) cut = i;
         while (mq.size() > cut) void'(mq.pop_back());
         if (mh > cut) mh = cut;
      end else if (pu) begin
         if (mq.size() == DEPTH) begin
            void'(mq.pop_front());
            if (mh > 0) mh--;
         end
         mq.push_back(pe);
      end else if (fx) begin
         if (mq.size() > 0) mq[mq.size() - 1].tgt = ft;
      end else if (cm) begin
         if (mq.size() > 0 && mh < mq.size() && mq[mh].seq <= ck) begin
            if (mh >= PL) void'(mq.pop_front());
            else mh++;
         end
      end
   endtask

   // driver: applies one cycle of requests and queues the expected state
   task automatic step(input string tag, input bit sq, input logic [SW-1:0] sk,
                       input bit pu, input logic [AW-1:0] pa, input logic [AW-1:0] pt,
                       input logic [SW-1:0] ps, input bit fx, input logic [AW-1:0] ft,
                       input bit cm, input logic [SW-1:0] ck);
      ent_t  e;
      snap_t s;
      @(negedge clk);
      sq_v = sq; sq_s = sk; push_v = pu; push_a = pa; push_t = pt; push_s = ps;
      fx_v = fx; fx_t = ft; cm_v = cm; cm_s = ck;
      e.addr = pa; e.tgt = pt; e.seq = ps;
      model(sq, sk, pu, e, fx, ft, cm, ck);
      s.tag = tag; s.cnt = mq.size(); s.head = mh;
      s.oseq = '0; s.yaddr = '0; s.ytgt = '0; s.yseq = '0;
      if (mq.size() > 0) begin
         s.oseq  = mq[0].seq;
         s.yaddr = mq[mq.size() - 1].addr;
         s.ytgt  = mq[mq.size() - 1].tgt;
         s.yseq  = mq[mq.size() - 1].seq;
      end
      for (int g = 0; g < PL; g++)
         s.taps[g] = (g < mq.size()) ? mq[mq.size() - 1 - g].tgt : '0;
      exp_q.push_back(s);
   endtask

   task automatic push(input string tag, input logic [SW-1:0] sn);
      step(tag, 0, 0, 1, AW'(16'h1000 + sn), AW'(16'h8000 + 3 * sn), sn, 0, 0, 0, 0);
   endtask
   task automatic commit(input string tag, input logic [SW-1:0] sn);
      step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, sn);
   endtask
   task automatic squash(input string tag, input logic [SW-1:0] sn);
      step(tag, 1, sn, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic fix(input string tag, input logic [AW-1:0] t);
      step(tag, 0, 0, 0, 0, 0, 0, 1, t, 0, 0);
   endtask

   // monitor: pops one expectation per edge and compares away from the edge
   always @(posedge clk) begin
      #5;
      if (exp_q.size() > 0) begin
         snap_t s;
         s = exp_q.pop_front();
         chk(s.tag, "count", count_o, s.cnt);
         chk(s.tag, "head", head_o, s.head);
         if (s.cnt > 0) begin
            chk(s.tag, "oldest_seq", oldest_seq_o, s.oseq);
            chk(s.tag, "young_addr", young_addr_o, s.yaddr);
            chk(s.tag, "young_tgt", young_tgt_o, s.ytgt);
            chk(s.tag, "young_seq", young_seq_o, s.yseq);
         end
         for (int g = 0; g < PL; g++) begin
            chk({s.tag, "/R10"}, $sformatf("tap_valid[%0d]", g), tap_valid_o[g], g < s.cnt);
            if (g < s.cnt)
               chk({s.tag, "/R10"}, $sformatf("tap[%0d]", g), tap_tgt_o[g*AW +: AW], s.taps[g]);
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "count", count_o, 0);
      chk("R1", "head", head_o, 0);
      chk("R1", "tap_valid", tap_valid_o, 0);

      commit("R6 empty", 8'd50);
      fix("R9 empty", 16'hdead);
      for (int i = 10; i <= 14; i++) push("R2", SW'(i));
      commit("R6 seq above", 8'd9);
      commit("R4", 8'd10);
      commit("R4", 8'd11);
      commit("R4", 8'd12);
      commit("R5", 8'd13);
      commit("R5", 8'd14);
      commit("R6 head at count", 8'd14);
      for (int i = 15; i <= 19; i++) push("R2 wrap", SW'(i));
      push("R3", 8'd20);
      push("R3", 8'd21);
      fix("R9", 16'h4242);
      squash("R8", 8'd25);
      squash("R7 mid", 8'd18);
      step("R11 squash over push", 1, 8'd16, 1, 16'h1111, 16'h2222, 8'd30, 0, 0, 0, 0);
      step("R11 push over fix", 0, 0, 1, 16'h1333, 16'h2444, 8'd31, 1, 16'h5555, 0, 0);
      step("R11 fix over commit", 0, 0, 0, 0, 0, 0, 1, 16'h6666, 1, 8'd31);
      for (int i = 32; i <= 40; i++) push("R3 refill", SW'(i));
      commit("R4 after overflow", 8'd100);
      squash("R7 clamp head", 8'd34);
      squash("R7 all", 8'd0);
      push("R2 after empty", 8'd200);
      commit("R4 unsigned", 8'd255);
      step("idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule